// File: doc/BRIEF.md
# Conditional Pixel Write Unit

This unit sits between a rendering engine and the pixel storage. It takes one pixel write request at a time, reads the stored depth word, the stored window ID and the fast-clear valid bit at the pixel's address, and decides which planes the pixel may update. It then drives the write enables for the image, depth and fast-clear planes. The stored window ID is 10 bits wide. The upper four bits form the coarse group ID and the lower six bits form the fine ID.

A per-request mode bit selects how the depth planes are used. In hidden-surface mode the depth word is a distance, and a pixel wins only if it is strictly closer than what is stored. A cleared fast-clear bit marks the stored depth as stale, and in that case the depth test always passes. In ID-extension mode the depth word holds extra clipping ID bits. These bits must match exactly together with the window ID, no depth test is done, and the depth planes are never overwritten.

Each request passes through three phases after acceptance: read, compare and write. The storage is external and synchronous. Read data returns in the cycle after the read strobe, and writes land at the clock edge that closes the write phase.

Top module: `pix_commit_unit`

## Requirements
- R1: After synchronous reset `req_ready` is 1, and `rd_en`, `img_we`, `dep_we` and `fc_we` are 0.
- R2: A request is accepted at a clock edge where `req_valid` and `req_ready` are both 1. `rd_en` is high for exactly the next cycle, with `rd_addr` equal to the request address. Any write enables are high only two cycles after that, for one cycle. `req_ready` stays low from acceptance until the cycle after the write phase.
- R3: In hidden-surface mode (`req_ext`=0) with a stored fast-clear bit of 1, the pixel passes only when `req_depth` is strictly less than the stored depth (unsigned). A depth equal to or greater than the stored value blocks every write.
- R4: In hidden-surface mode with a stored fast-clear bit of 0, the depth test passes whatever the depth values are.
- R5: If `req_wid` differs from the stored window ID in any bit, either in the group field (bits 9:6) or in the fine field (bits 5:0), neither image nor depth is written.
- R6: In ID-extension mode (`req_ext`=1) the pixel passes only when both the window ID and the 24-bit depth word equal the stored values. `dep_we` is never asserted in this mode, and the depth ordering has no effect.
- R7: `req_mask` bit 0 enables the image write and bit 1 enables the depth write. A target whose mask bit is 0 is never written, even when all tests pass.
- R8: `fc_we` (which writes a 1) is asserted in the write phase exactly when `img_we` or `dep_we` is asserted. `wr_addr`, `wr_color` and `wr_depth` carry the accepted request's address, colour and depth.
- R9: The request fields and `req_ext` are captured at acceptance. Changes to them while a request is in flight do not affect its outcome.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle, request can be taken |
| req_ext | input | 1 | 0 = hidden-surface mode, 1 = ID-extension mode |
| req_addr | input | ADDR_W | Pixel address |
| req_color | input | COLOR_W | Pixel colour |
| req_depth | input | DEPTH_W | Pixel depth or extension ID |
| req_wid | input | WID_W | Current window ID |
| req_mask | input | 2 | Bit 0 image, bit 1 depth |
| rd_en | output | 1 | Storage read strobe |
| rd_addr | output | ADDR_W | Storage read address |
| rd_depth | input | DEPTH_W | Stored depth, one cycle after `rd_en` |
| rd_wid | input | WID_W | Stored window ID, one cycle after `rd_en` |
| rd_fc | input | 1 | Stored fast-clear valid bit, one cycle after `rd_en` |
| wr_addr | output | ADDR_W | Write address |
| wr_color | output | COLOR_W | Image write data |
| wr_depth | output | DEPTH_W | Depth write data |
| img_we | output | 1 | Image plane write enable |
| dep_we | output | 1 | Depth plane write enable |
| fc_we | output | 1 | Fast-clear bit write enable (writes 1) |

## Verification
A wrong phase register shows up on the ports within one request. The read strobe, the write enables or `req_ready` appear in the wrong cycle, and the bench compares all of them against its model every cycle. A wrong verdict, or a field captured badly, shows as a wrong write enable or wrong write data in the single write cycle of that request. It also leaves the storage model different from the reference copy, and the bench compares the two at the end of the run. Corrupted stored state also affects later requests to the same address. This is covered by tests that repeat a pixel at an equal depth.

// File: rtl/pcu_pkg.sv
package pcu_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_READ  = 2'd1,
        PH_JUDGE = 2'd2,
        PH_WRITE = 2'd3
    } pcu_phase_e;

    typedef struct packed {
        logic img;
        logic dep;
        logic fc;
    } pcu_verdict_t;

    localparam int MASK_IMG = 0;
    localparam int MASK_DEP = 1;

    function automatic pcu_verdict_t pcu_decide(
        input logic       ext,
        input logic       id_same,
        input logic       depth_same,
        input logic       depth_closer,
        input logic       stored_valid,
        input logic [1:0] mask
    );
        pcu_verdict_t v;
        logic pass;
        if (ext)
            pass = id_same && depth_same;
        else
            pass = id_same && (!stored_valid || depth_closer);
        v.img = pass && mask[MASK_IMG];
        v.dep = pass && mask[MASK_DEP] && !ext;
        v.fc  = v.img || v.dep;
        return v;
    endfunction

endpackage

// File: rtl/pcu_judge.sv
module pcu_judge
    import pcu_pkg::*;
#(
    parameter int DEPTH_W = 24,
    parameter int WID_W   = 10,
    parameter int GRP_W   = 4
) (
    input  logic               op_ext,
    input  logic [DEPTH_W-1:0] op_depth,
    input  logic [WID_W-1:0]   op_wid,
    input  logic [1:0]         op_mask,
    input  logic [DEPTH_W-1:0] rd_depth,
    input  logic [WID_W-1:0]   rd_wid,
    input  logic               rd_fc,
    output pcu_verdict_t       verdict
);
    localparam int FINE_W = WID_W - GRP_W;

    logic grp_same, fine_same;

    assign grp_same  = (op_wid[WID_W-1:FINE_W] == rd_wid[WID_W-1:FINE_W]);
    assign fine_same = (op_wid[FINE_W-1:0] == rd_wid[FINE_W-1:0]);

    always_comb begin
        verdict = pcu_decide(op_ext,
                             grp_same && fine_same,
                             op_depth == rd_depth,
                             op_depth <  rd_depth,
                             rd_fc,
                             op_mask);
    end

endmodule

// File: rtl/pcu_sequencer.sv
module pcu_sequencer
    import pcu_pkg::*;
#(
    parameter int ADDR_W  = 12,
    parameter int COLOR_W = 24,
    parameter int DEPTH_W = 24,
    parameter int WID_W   = 10
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic               req_ext,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [COLOR_W-1:0] req_color,
    input  logic [DEPTH_W-1:0] req_depth,
    input  logic [WID_W-1:0]   req_wid,
    input  logic [1:0]         req_mask,
    input  pcu_verdict_t       verdict,
    output logic               rd_en,
    output logic               op_ext,
    output logic [ADDR_W-1:0]  op_addr,
    output logic [COLOR_W-1:0] op_color,
    output logic [DEPTH_W-1:0] op_depth,
    output logic [WID_W-1:0]   op_wid,
    output logic [1:0]         op_mask,
    output logic               img_we,
    output logic               dep_we,
    output logic               fc_we
);
    pcu_phase_e   phase_q;
    pcu_verdict_t verdict_q;

    assign req_ready = (phase_q == PH_IDLE);
    assign rd_en     = (phase_q == PH_READ);
    assign img_we    = (phase_q == PH_WRITE) && verdict_q.img;
    assign dep_we    = (phase_q == PH_WRITE) && verdict_q.dep;
    assign fc_we     = (phase_q == PH_WRITE) && verdict_q.fc;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q   <= PH_IDLE;
            verdict_q <= '0;
            op_ext    <= 1'b0;
            op_addr   <= '0;
            op_color  <= '0;
            op_depth  <= '0;
            op_wid    <= '0;
            op_mask   <= '0;
        end else begin
            unique case (phase_q)
                PH_IDLE: if (req_valid) begin
                    phase_q  <= PH_READ;
                    op_ext   <= req_ext;
                    op_addr  <= req_addr;
                    op_color <= req_color;
                    op_depth <= req_depth;
                    op_wid   <= req_wid;
                    op_mask  <= req_mask;
                end
                PH_READ:  phase_q <= PH_JUDGE;
                PH_JUDGE: begin
                    phase_q   <= PH_WRITE;
                    verdict_q <= verdict;
                end
                PH_WRITE: phase_q <= PH_IDLE;
                default:  phase_q <= PH_IDLE;
            endcase
        end
    end

    // R1: the first cycle after reset is idle
    a_r1_reset_idle: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (req_ready && !rd_en && !img_we && !dep_we && !fc_we));

    // R2: the read strobe lasts one cycle
    a_r2_read_single: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> !rd_en);

    // R2: writes come two cycles after the read
    a_r2_write_after_read: assert property (@(posedge clk) disable iff (rst)
        (img_we || dep_we || fc_we) |-> $past(rd_en, 2));

    // R2: no write while a new request can be taken
    a_r2_idle_no_write: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> !(img_we || dep_we || fc_we));

    // R6: ID-extension mode never writes the depth planes
    a_r6_ext_keeps_depth: assert property (@(posedge clk) disable iff (rst)
        dep_we |-> !op_ext);

    // R7: masked-off targets stay untouched
    a_r7_image_masked: assert property (@(posedge clk) disable iff (rst)
        img_we |-> op_mask[MASK_IMG]);
    a_r7_depth_masked: assert property (@(posedge clk) disable iff (rst)
        dep_we |-> op_mask[MASK_DEP]);

    // R8: any plane write also marks the pixel valid
    a_r8_mark_valid: assert property (@(posedge clk) disable iff (rst)
        (img_we || dep_we) |-> fc_we);

endmodule

// File: rtl/pix_commit_unit.sv
module pix_commit_unit
    import pcu_pkg::*;
#(
    parameter int ADDR_W  = 12,
    parameter int COLOR_W = 24,
    parameter int DEPTH_W = 24,
    parameter int WID_W   = 10,
    parameter int GRP_W   = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic               req_ext,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [COLOR_W-1:0] req_color,
    input  logic [DEPTH_W-1:0] req_depth,
    input  logic [WID_W-1:0]   req_wid,
    input  logic [1:0]         req_mask,
    output logic               rd_en,
    output logic [ADDR_W-1:0]  rd_addr,
    input  logic [DEPTH_W-1:0] rd_depth,
    input  logic [WID_W-1:0]   rd_wid,
    input  logic               rd_fc,
    output logic [ADDR_W-1:0]  wr_addr,
    output logic [COLOR_W-1:0] wr_color,
    output logic [DEPTH_W-1:0] wr_depth,
    output logic               img_we,
    output logic               dep_we,
    output logic               fc_we
);
    logic               op_ext;
    logic [ADDR_W-1:0]  op_addr;
    logic [COLOR_W-1:0] op_color;
    logic [DEPTH_W-1:0] op_depth;
    logic [WID_W-1:0]   op_wid;
    logic [1:0]         op_mask;
    pcu_verdict_t       verdict;

    pcu_sequencer #(
        .ADDR_W(ADDR_W), .COLOR_W(COLOR_W), .DEPTH_W(DEPTH_W), .WID_W(WID_W)
    ) u_seq (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_ext(req_ext),
        .req_addr(req_addr), .req_color(req_color), .req_depth(req_depth),
        .req_wid(req_wid), .req_mask(req_mask),
        .verdict(verdict), .rd_en(rd_en),
        .op_ext(op_ext), .op_addr(op_addr), .op_color(op_color),
        .op_depth(op_depth), .op_wid(op_wid), .op_mask(op_mask),
        .img_we(img_we), .dep_we(dep_we), .fc_we(fc_we)
    );

    pcu_judge #(
        .DEPTH_W(DEPTH_W), .WID_W(WID_W), .GRP_W(GRP_W)
    ) u_judge (
        .op_ext(op_ext), .op_depth(op_depth), .op_wid(op_wid), .op_mask(op_mask),
        .rd_depth(rd_depth), .rd_wid(rd_wid), .rd_fc(rd_fc),
        .verdict(verdict)
    );

    assign rd_addr  = op_addr;
    assign wr_addr  = op_addr;
    assign wr_color = op_color;
    assign wr_depth = op_depth;

endmodule

// File: tb/sim_pix_commit_unit.sv
`timescale 1ns/1ps
module sim_pix_commit_unit;
    localparam int AW = 6;
    localparam int NPIX = 1 << AW;
    localparam logic [9:0] OWN_ID = 10'h2A5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic          req_valid = 1'b0, req_ext = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [23:0]   req_color = '0, req_depth = '0;
    logic [9:0]    req_wid = '0;
    logic [1:0]    req_mask = '0;
    logic          req_ready, rd_en, img_we, dep_we, fc_we;
    logic [AW-1:0] rd_addr, wr_addr;
    logic [23:0]   wr_color, wr_depth;
    logic [23:0]   rd_depth;
    logic [9:0]    rd_wid;
    logic          rd_fc;

    pix_commit_unit #(.ADDR_W(AW)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_ext(req_ext), .req_addr(req_addr), .req_color(req_color),
        .req_depth(req_depth), .req_wid(req_wid), .req_mask(req_mask),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_depth(rd_depth), .rd_wid(rd_wid),
        .rd_fc(rd_fc), .wr_addr(wr_addr), .wr_color(wr_color), .wr_depth(wr_depth),
        .img_we(img_we), .dep_we(dep_we), .fc_we(fc_we)
    );

    // preload port shared by storage and reference
    logic          pl_en = 1'b0, pl_fc = 1'b0;
    logic [AW-1:0] pl_addr = '0;
    logic [23:0]   pl_dep = '0;

    // storage seen by the unit
    logic [23:0] m_dep [NPIX];
    logic [23:0] m_col [NPIX];
    logic [9:0]  m_wid [NPIX];
    logic        m_fc  [NPIX];
    always @(posedge clk) begin
        if (pl_en) begin
            m_dep[pl_addr] <= pl_dep; m_col[pl_addr] <= '0;
            m_wid[pl_addr] <= OWN_ID; m_fc[pl_addr] <= pl_fc;
        end
        if (rd_en) begin
            rd_depth <= m_dep[rd_addr]; rd_wid <= m_wid[rd_addr]; rd_fc <= m_fc[rd_addr];
        end
        if (img_we) m_col[wr_addr] <= wr_color;
        if (dep_we) m_dep[wr_addr] <= wr_depth;
        if (fc_we)  m_fc[wr_addr]  <= 1'b1;
    end

    // behavioural reference
    logic [23:0] r_dep [NPIX];
    logic [23:0] r_col [NPIX];
    logic [9:0]  r_wid [NPIX];
    logic        r_fc  [NPIX];
    int          phase = 0;
    logic [AW-1:0] e_addr;
    logic [23:0] e_col, e_dep;
    logic        e_img, e_dwe, e_fc;
    string       cur_tag = "R2", e_tag = "R2";

    always @(posedge clk) begin
        if (pl_en) begin
            r_dep[pl_addr] = pl_dep; r_col[pl_addr] = '0;
            r_wid[pl_addr] = OWN_ID; r_fc[pl_addr] = pl_fc;
        end
        if (rst) phase = 0;
        else begin
            case (phase)
                0: if (req_valid) begin
                    logic ok;
                    e_addr = req_addr; e_col = req_color; e_dep = req_depth; e_tag = cur_tag;
                    if (req_ext)
                        ok = (req_wid == r_wid[req_addr]) && (req_depth == r_dep[req_addr]);
                    else
                        ok = (req_wid == r_wid[req_addr]) &&
                             (!r_fc[req_addr] || (req_depth < r_dep[req_addr]));
                    e_img = ok && req_mask[0];
                    e_dwe = ok && req_mask[1] && !req_ext;
                    e_fc  = e_img || e_dwe;
                    phase = 1;
                end
                1: phase = 2;
                2: phase = 3;
                default: begin
                    if (e_img) r_col[e_addr] = e_col;
                    if (e_dwe) r_dep[e_addr] = e_dep;
                    if (e_fc)  r_fc[e_addr]  = 1'b1;
                    phase = 0;
                end
            endcase
        end
    end

    int n_chk = 0, n_bad = 0;
    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    logic chk_on = 1'b0;
    always @(negedge clk) begin
        if (chk_on) begin
            chk("R2 req_ready", req_ready, phase == 0);
            chk("R2 rd_en", rd_en, phase == 1);
            if (phase == 1) chk("R2 rd_addr", rd_addr, e_addr);
            chk({e_tag, " img_we"}, img_we, phase == 3 && e_img);
            chk({e_tag, " dep_we"}, dep_we, phase == 3 && e_dwe);
            chk("R8 fc_we", fc_we, phase == 3 && e_fc);
            if (phase == 3 && e_fc) begin
                chk("R8 wr_addr", wr_addr, e_addr);
                chk("R8 wr_color", wr_color, e_col);
                chk("R8 wr_depth", wr_depth, e_dep);
            end
        end
    end

    // called at a negedge with the unit idle; returns at a negedge, idle again
    task automatic issue(input string tag, input logic [AW-1:0] a, input logic [23:0] col,
                         input logic [23:0] dep, input logic [9:0] wid, input logic [1:0] mask,
                         input logic ext, input bit keep, input bit scramble);
        cur_tag = tag;
        req_addr = a; req_color = col; req_depth = dep; req_wid = wid;
        req_mask = mask; req_ext = ext; req_valid = 1'b1;
        @(negedge clk);
        if (!keep) req_valid = 1'b0;
        if (scramble) begin
            req_addr = ~a; req_color = ~col; req_depth = 24'h0; req_wid = ~wid;
            req_mask = 2'b00; req_ext = ~ext;
        end
        repeat (3) @(negedge clk);
    endtask

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_chk++; n_bad++;
            $display("FAIL R2 watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        for (int a = 0; a < NPIX; a++) begin
            @(negedge clk);
            pl_en = 1'b1; pl_addr = AW'(a);
            pl_dep = (a == 2) ? 24'd5 : 24'd1000;
            pl_fc  = (a != 2);
        end
        @(negedge clk); pl_en = 1'b0;
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        chk("R1 req_ready", req_ready, 1);
        chk("R1 rd_en", rd_en, 0);
        chk("R1 write enables", {img_we, dep_we, fc_we}, 0);
        chk_on = 1'b1;

        issue("R3", 1, 24'h111111, 24'd999, OWN_ID, 2'b11, 0, 0, 0);   // closer: pass
        issue("R3", 1, 24'h222222, 24'd999, OWN_ID, 2'b11, 0, 0, 0);   // equal: blocked
        issue("R3", 1, 24'h333333, 24'd1001, OWN_ID, 2'b11, 0, 0, 0);  // farther: blocked
        issue("R4", 2, 24'h444444, 24'hFFFFF0, OWN_ID, 2'b11, 0, 0, 0); // stale: pass
        issue("R4", 2, 24'h454545, 24'hFFFFF0, OWN_ID, 2'b11, 0, 0, 0); // now valid+equal
        issue("R5", 3, 24'h555555, 24'd1, OWN_ID ^ 10'h040, 2'b11, 0, 0, 0);
        issue("R5", 3, 24'h565656, 24'd1, OWN_ID ^ 10'h001, 2'b11, 0, 0, 0);
        issue("R7", 4, 24'h777777, 24'd10, OWN_ID, 2'b01, 0, 0, 0);
        issue("R7", 4, 24'h787878, 24'd9, OWN_ID, 2'b10, 0, 0, 0);
        issue("R7", 7, 24'h797979, 24'd8, OWN_ID, 2'b00, 0, 0, 0);
        issue("R6", 5, 24'h666666, 24'd1000, OWN_ID, 2'b11, 1, 0, 0);
        issue("R6", 5, 24'h676767, 24'd3, OWN_ID, 2'b11, 1, 0, 0);
        issue("R6", 5, 24'h686868, 24'd1000, OWN_ID ^ 10'h200, 2'b11, 1, 0, 0);
        issue("R9", 6, 24'h999999, 24'd20, OWN_ID, 2'b11, 0, 0, 1);
        issue("R2", 8, 24'haaaaaa, 24'd30, OWN_ID, 2'b11, 0, 1, 0);    // valid held high
        issue("R2", 9, 24'hbbbbbb, 24'd31, OWN_ID, 2'b01, 0, 0, 0);

        chk_on = 1'b0;
        for (int a = 0; a < NPIX; a++) begin
            chk("R8 stored depth", m_dep[a], r_dep[a]);
            chk("R8 stored colour", m_col[a], r_col[a]);
            chk("R8 stored valid", m_fc[a], r_fc[a]);
        end
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule